// File: doc/BRIEF.md
# Serial Port Register Set with Interrupt Resolution

This block is the programmer-visible side of a 16550-compatible serial port. A host reaches eight byte-wide registers through a small bus: a 3-bit offset, separate read and write strobes, a write byte and a read byte. Received bytes arrive on a valid/ready stream and are queued in an internal receive FIFO. Bytes written to the data register leave on a transmit strobe. The bit-level shifter, the baud timer and the modem pins sit outside the block. A line-status overrun, queued receive data, a pending transmit-empty event and modem-status changes are ranked in a fixed order and drive one level-sensitive interrupt line.

The read byte is combinational and is valid during the cycle in which `bus_rd` is high. The side effects of a read (FIFO pop, flag clears) take place at the clock edge that ends that cycle. Register state changes on the edge after a write. `irq` is decoded from registered state, so it follows an access one cycle later.

Receive stream rules: a byte transfers on a rising edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is low when the FIFO is at its current depth. It is also low in a cycle that flushes the FIFO. In loopback `rx_ready` is always high, and the accepted bytes are discarded. The transmit side has no back-pressure: `tx_valid` is a one-cycle strobe with `tx_data`, and the sink must take it.

Top module: `uart_csr_core`

## Requirements
- R1: Interrupt cause priority runs from high to low as follows: overrun with IER bit 2, FIFO non-empty with IER bit 0, transmit-empty pending with IER bit 1, and any nonzero modem delta with IER bit 3. The identification register (offset 2, read) reports the codes 0x6, 0x4, 0x2 and 0x0 for these causes, or 0x1 when none is active. `irq` is high exactly when a cause is active.
- R2: The transmit-empty pending flag is set by every data-register write (offset 0, DLAB clear). It is also set by an IER write that takes bit 1 from 0 to 1. A read of the identification register that reports code 0x2 clears it.
- R3: The IER (offset 1) stores only the written bits 3:0 and the MCR (offset 4) stores only bits 4:0. Both read back zero-extended. The LCR (offset 3) and the scratch byte (offset 7) store and return all 8 bits.
- R4: While LCR bit 7 (DLAB) is set, offsets 0 and 1 read and write the low and high divisor bytes. While DLAB is clear, the divisor cannot change. The divisor resets to 1843200/9600/16 = 12.
- R5: The receive FIFO holds one byte while FIFO mode is off and DEPTH bytes while it is on. The data-ready flag (LSR bit 0) is set exactly when the FIFO is non-empty. Outside loopback, `rx_ready` is low while the FIFO is full or being flushed.
- R6: A write to the FIFO control register (offset 2) follows these rules. If it changes bit 0, the FIFO is flushed. If bit 0 is written as 1 together with bit 1, the FIFO is also flushed. If bit 0 is written as 0, FIFO mode turns off and the other stored bits are kept. If FIFO mode is on, identification reads have bits 7:6 set.
- R7: A data read with DLAB clear returns the oldest FIFO byte and removes it. When the FIFO is empty, the read returns 0x00.
- R8: The line status register (offset 5) reads bits 6 and 5 as 1, bit 1 as the overrun flag and bit 0 as data-ready. Reading it clears the overrun flag.
- R9: The modem status register (offset 6) has the deltas in bits 3:0 (CTS change, DSR change, RI trailing edge, DCD change) and CTS, DSR, RI and DCD in bits 4 to 7. Outside loopback, DCD and DSR read 1 and CTS and RI read 0. Reading the register clears the deltas.
- R10: An MCR write sets a delta bit for each change in CTS, DSR or DCD, and sets the RI delta when RI falls from 1 to 0. Deltas already set stay set.
- R11: Loopback (MCR bit 4) behaves as follows. RTS drives CTS, DTR drives DSR, OUT1 drives RI and OUT2 drives DCD. A data write is queued into the FIFO and does not appear at the transmit port. If the FIFO is full, the byte is lost and the overrun flag is set.
- R12: When `bus_wr` and `bus_rd` are high together, only the write takes effect. The read has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte accepted |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request, level |

## Verification
On every cycle the assertions check the following: `irq` needs at least one enable bit, the FIFO count stays within the current depth, the divisor does not change while DLAB is clear, and a data write leaves the transmit-empty flag set. They also check that reading the line status or modem status register clears the matching flags, and that no transmit strobe follows a loopback write. Only the bench scenarios can show the order in which causes are ranked and the exact identification codes. The same holds for the delta patterns produced by MCR sequences, FIFO resizing and flushing, overrun from a full loopback FIFO, and a write masking a concurrent read.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;

  typedef enum logic [3:0] {
    CAUSE_MODEM = 4'h0,
    CAUSE_NONE  = 4'h1,
    CAUSE_TXE   = 4'h2,
    CAUSE_RXD   = 4'h4,
    CAUSE_LINE  = 4'h6
  } cause_e;

  // Modem line nibble {DCD, RI, DSR, CTS} seen for a given control value
  function automatic logic [3:0] modem_lines(input logic [4:0] ctl);
    logic [3:0] l;
    if (ctl[4]) begin
      l[0] = ctl[1];
      l[1] = ctl[0];
      l[2] = ctl[2];
      l[3] = ctl[3];
    end else begin
      l = 4'b1010;
    end
    return l;
  endfunction

endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         deep,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [$clog2(DEPTH+1)-1:0]   limit,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign limit = deep ? CW'(DEPTH) : CW'(1);
  assign full  = (count >= limit);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/uart_irq_resolve.sv
module uart_irq_resolve
  import uart_csr_pkg::*;
(
  input  logic [3:0] ier,
  input  logic       overrun,
  input  logic       rx_avail,
  input  logic       txe_pend,
  input  logic       delta_any,
  output cause_e     cause,
  output logic       irq
);
  always_comb begin
    if (overrun && ier[2])        cause = CAUSE_LINE;
    else if (rx_avail && ier[0])  cause = CAUSE_RXD;
    else if (txe_pend && ier[1])  cause = CAUSE_TXE;
    else if (delta_any && ier[3]) cause = CAUSE_MODEM;
    else                          cause = CAUSE_NONE;
  end

  assign irq = (cause != CAUSE_NONE);

endmodule

// File: rtl/uart_csr_core.sv
module uart_csr_core
  import uart_csr_pkg::*;
#(
  parameter int RX_DEPTH   = 16,
  parameter int REF_CLK_HZ = 1843200,
  parameter int RESET_BAUD = 9600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       irq
);
  localparam int          CW       = $clog2(RX_DEPTH + 1);
  localparam logic [15:0] DIV_INIT = 16'(REF_CLK_HZ / RESET_BAUD / 16);

  logic [3:0] ier_q;
  logic [7:0] lcr_q;
  logic [4:0] mcr_q;
  logic       oe_q;
  logic [3:0] delta_q;
  logic [7:0] fcr_q;
  logic [7:0] scr_q;
  logic [7:0] dll_q, dlh_q;
  logic       thre_q;
  logic       txv_q;
  logic [7:0] txd_q;

  logic          rd_en, wr_en, dlab, loop;
  logic          fifo_flush, fifo_push, fifo_pop, fifo_full;
  logic [7:0]    fifo_head, fifo_in;
  logic [CW-1:0] fifo_cnt, fifo_lim;
  logic          loop_wr;
  cause_e        cause;
  logic [3:0]    lines_now, lines_new, delta_new;

  assign wr_en = bus_wr;
  assign rd_en = bus_rd & ~bus_wr;
  assign dlab  = lcr_q[7];
  assign loop  = mcr_q[4];

  // Receive path and FIFO control
  assign fifo_flush = wr_en && (bus_addr == OFS_IIR) &&
                      ((bus_wdata[0] != fcr_q[0]) || (bus_wdata[0] && bus_wdata[1]));
  assign loop_wr    = wr_en && (bus_addr == OFS_DATA) && !dlab && loop;
  assign rx_ready   = loop | (~fifo_full & ~fifo_flush);
  assign fifo_push  = loop ? (loop_wr && !fifo_full)
                           : (rx_valid && rx_ready);
  assign fifo_in    = loop ? bus_wdata : rx_data;
  assign fifo_pop   = rd_en && (bus_addr == OFS_DATA) && !dlab && (fifo_cnt != '0);

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .DW(8)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .deep      (fcr_q[0]),
    .flush     (fifo_flush),
    .push      (fifo_push),
    .push_data (fifo_in),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .count     (fifo_cnt),
    .limit     (fifo_lim),
    .full      (fifo_full)
  );

  uart_irq_resolve u_irq (
    .ier       (ier_q),
    .overrun   (oe_q),
    .rx_avail  (fifo_cnt != '0),
    .txe_pend  (thre_q),
    .delta_any (delta_q != 4'h0),
    .cause     (cause),
    .irq       (irq)
  );

  // Modem status deltas produced by a control write
  assign lines_now = modem_lines(mcr_q);
  assign lines_new = modem_lines(bus_wdata[4:0]);
  assign delta_new = {lines_now[3] ^ lines_new[3],
                      lines_now[2] & ~lines_new[2],
                      lines_now[1] ^ lines_new[1],
                      lines_now[0] ^ lines_new[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q   <= '0;
      lcr_q   <= '0;
      mcr_q   <= '0;
      oe_q    <= 1'b0;
      delta_q <= '0;
      fcr_q   <= '0;
      scr_q   <= '0;
      dll_q   <= DIV_INIT[7:0];
      dlh_q   <= DIV_INIT[15:8];
      thre_q  <= 1'b0;
      txv_q   <= 1'b0;
      txd_q   <= '0;
    end else begin
      txv_q <= 1'b0;
      if (wr_en) begin
        case (bus_addr)
          OFS_DATA: begin
            if (dlab) begin
              dll_q <= bus_wdata;
            end else begin
              thre_q <= 1'b1;
              if (loop) begin
                if (fifo_full) oe_q <= 1'b1;
              end else begin
                txv_q <= 1'b1;
                txd_q <= bus_wdata;
              end
            end
          end
          OFS_IER: begin
            if (dlab) begin
              dlh_q <= bus_wdata;
            end else begin
              if (!ier_q[1] && bus_wdata[1]) thre_q <= 1'b1;
              ier_q <= bus_wdata[3:0];
            end
          end
          OFS_IIR: begin
            if (bus_wdata[0]) fcr_q <= bus_wdata & FCR_KEEP_MASK;
            else              fcr_q <= {fcr_q[7:1], 1'b0};
          end
          OFS_LCR: lcr_q <= bus_wdata;
          OFS_MCR: begin
            mcr_q   <= bus_wdata[4:0];
            delta_q <= delta_q | delta_new;
          end
          OFS_SCR: scr_q <= bus_wdata;
          default: ;
        endcase
      end else if (rd_en) begin
        case (bus_addr)
          OFS_IIR: if (cause == CAUSE_TXE) thre_q <= 1'b0;
          OFS_LSR: oe_q <= 1'b0;
          OFS_MSR: delta_q <= '0;
          default: ;
        endcase
      end
    end
  end

  // Read mux
  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = dlab ? dll_q : ((fifo_cnt != '0) ? fifo_head : 8'h00);
      OFS_IER:  bus_rdata = dlab ? dlh_q : {4'h0, ier_q};
      OFS_IIR:  bus_rdata = {{2{fcr_q[0]}}, 2'b00, cause};
      OFS_LCR:  bus_rdata = lcr_q;
      OFS_MCR:  bus_rdata = {3'b000, mcr_q};
      OFS_LSR:  bus_rdata = {1'b0, 2'b11, 3'b000, oe_q, fifo_cnt != '0};
      OFS_MSR:  bus_rdata = {lines_now, delta_q};
      default:  bus_rdata = scr_q;
    endcase
  end

  assign tx_valid = txv_q;
  assign tx_data  = txd_q;

endmodule

// File: rtl/uart_csr_core_chk.sv
module uart_csr_core_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          irq,
  input logic          tx_valid,
  input logic [3:0]    ier_q,
  input logic [7:0]    lcr_q,
  input logic [4:0]    mcr_q,
  input logic          oe_q,
  input logic [3:0]    delta_q,
  input logic          thre_q,
  input logic [7:0]    dll_q,
  input logic [7:0]    dlh_q,
  input logic [CW-1:0] fifo_cnt,
  input logic [CW-1:0] fifo_lim
);
  // R1
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ier_q != 4'h0));

  // R2
  thre_after_data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && !lcr_q[7]) |=> thre_q);

  // R4
  divisor_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_q[7] |=> $stable({dlh_q, dll_q}));

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= fifo_lim);

  // R8
  oe_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 3'd5) |=> !oe_q);

  // R9
  delta_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 3'd6) |=> (delta_q == 4'h0));

  // R11
  no_tx_in_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !$past(mcr_q[4]));

endmodule

bind uart_csr_core uart_csr_core_chk #(.CW($clog2(RX_DEPTH + 1))) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .irq      (irq),
  .tx_valid (tx_valid),
  .ier_q    (ier_q),
  .lcr_q    (lcr_q),
  .mcr_q    (mcr_q),
  .oe_q     (oe_q),
  .delta_q  (delta_q),
  .thre_q   (thre_q),
  .dll_q    (dll_q),
  .dlh_q    (dlh_q),
  .fifo_cnt (fifo_cnt),
  .fifo_lim (fifo_lim)
);

// File: tb/uart_csr_core_bench.sv
`timescale 1ns/1ps
module uart_csr_core_bench;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = '0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       irq;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_csr_core #(.RX_DEPTH(DEPTH)) u_uart_csr_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] q[$];
  logic [3:0] m_ier, m_dl;
  logic [7:0] m_lcr, m_fcr, m_scr, m_dll, m_dlh, m_txd;
  logic [4:0] m_mcr;
  bit         m_oe, m_thre, m_txv;
  bit         t_loop, t_rdy, t_dlab;
  logic [3:0] t_cause, t_old, t_new;

  function automatic int cap();
    if (m_fcr[0]) return DEPTH;
    return 1;
  endfunction

  function automatic logic [3:0] lines(input logic [4:0] mc);
    logic cts, dsr, ri, dcd;
    cts = 1'b0; ri = 1'b0; dsr = 1'b1; dcd = 1'b1;
    if (mc[4]) begin
      dcd = mc[3]; ri = mc[2]; cts = mc[1]; dsr = mc[0];
    end
    return {dcd, ri, dsr, cts};
  endfunction

  function automatic logic [3:0] m_cause();
    if (m_oe && m_ier[2]) return 4'h6;
    if (q.size() > 0 && m_ier[0]) return 4'h4;
    if (m_thre && m_ier[1]) return 4'h2;
    if (m_dl != 0 && m_ier[3]) return 4'h0;
    return 4'h1;
  endfunction

  function automatic bit m_flush();
    return bus_wr && bus_addr == 3'd2 &&
           ((bus_wdata[0] != m_fcr[0]) || (bus_wdata[0] && bus_wdata[1]));
  endfunction

  function automatic bit m_ready();
    return m_mcr[4] || (q.size() < cap() && !m_flush());
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_dll : (q.size() > 0 ? q[0] : 8'h00);
      3'd1: return m_lcr[7] ? m_dlh : {4'h0, m_ier};
      3'd2: return {m_fcr[0] ? 2'b11 : 2'b00, 2'b00, m_cause()};
      3'd3: return m_lcr;
      3'd4: return {3'b000, m_mcr};
      3'd5: return {1'b0, 1'b1, 1'b1, 3'b000, m_oe, q.size() > 0};
      3'd6: return {lines(m_mcr), m_dl};
      default: return m_scr;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_ier = 0; m_dl = 0; m_lcr = 0; m_fcr = 0; m_scr = 0;
      m_dll = 8'd12; m_dlh = 8'd0; m_mcr = 0; m_oe = 0; m_thre = 0;
      m_txv = 0; m_txd = 0;
    end else begin
      t_loop  = m_mcr[4];
      t_rdy   = m_ready();
      t_dlab  = m_lcr[7];
      t_cause = m_cause();
      m_txv   = 0;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: if (t_dlab) m_dll = bus_wdata;
                else begin
                  m_thre = 1;
                  if (t_loop) begin
                    if (q.size() < cap()) q.push_back(bus_wdata); else m_oe = 1;
                  end else begin
                    m_txv = 1; m_txd = bus_wdata;
                  end
                end
          3'd1: if (t_dlab) m_dlh = bus_wdata;
                else begin
                  if (!m_ier[1] && bus_wdata[1]) m_thre = 1;
                  m_ier = bus_wdata[3:0];
                end
          3'd2: begin
                  if (m_flush()) q.delete();
                  if (bus_wdata[0]) m_fcr = bus_wdata & 8'hC9;
                  else m_fcr[0] = 1'b0;
                end
          3'd3: m_lcr = bus_wdata;
          3'd4: begin
                  t_old = lines(m_mcr);
                  t_new = lines(bus_wdata[4:0]);
                  m_dl[0] = m_dl[0] | (t_old[0] ^ t_new[0]);
                  m_dl[1] = m_dl[1] | (t_old[1] ^ t_new[1]);
                  m_dl[2] = m_dl[2] | (t_old[2] & ~t_new[2]);
                  m_dl[3] = m_dl[3] | (t_old[3] ^ t_new[3]);
                  m_mcr = bus_wdata[4:0];
                end
          3'd7: m_scr = bus_wdata;
          default: ;
        endcase
      end else if (bus_rd) begin
        case (bus_addr)
          3'd0: if (!t_dlab && q.size() > 0) void'(q.pop_front());
          3'd2: if (t_cause == 4'h2) m_thre = 0;
          3'd5: m_oe = 0;
          3'd6: m_dl = 0;
          default: ;
        endcase
      end
      if (rx_valid && t_rdy && !t_loop) q.push_back(rx_data);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 irq level", {7'd0, irq}, {7'd0, m_cause() != 4'h1});
      chk("R5 rx_ready", {7'd0, rx_ready}, {7'd0, m_ready()});
      chk("R11 tx_valid", {7'd0, tx_valid}, {7'd0, m_txv});
      if (m_txv) chk("R11 tx_data", tx_data, m_txd);
      if (bus_rd && !bus_wr) chk("R12 read data", bus_rdata, m_read(bus_addr));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic irq_is(input bit exp, input string tag);
    @(negedge clk);
    chk(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic rx_offer(input logic [7:0] d, input bit exp_ok, input string tag);
    @(posedge clk); #1;
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    chk(tag, {7'd0, rx_ready}, {7'd0, exp_ok});
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // reset state and divisor access
    irq_is(0, "R1 reset irq");
    rd(3'd2, 8'h01, "R1 reset iir");
    rd(3'd5, 8'h60, "R8 reset lsr");
    rd(3'd6, 8'hA0, "R9 reset msr");
    wr(3'd3, 8'h80);
    rd(3'd0, 8'd12, "R4 divisor low");
    rd(3'd1, 8'd0, "R4 divisor high");
    wr(3'd0, 8'h55);
    rd(3'd0, 8'h55, "R4 divisor write");
    irq_is(0, "R2 no pending from divisor write");
    wr(3'd3, 8'h03);
    rd(3'd3, 8'h03, "R3 lcr");
    wr(3'd7, 8'hA5);
    rd(3'd7, 8'hA5, "R3 scratch");

    // transmit-empty pending
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R3 ier mask");
    irq_is(1, "R2 enable edge");
    rd(3'd2, 8'h02, "R2 iir txe");
    irq_is(0, "R2 cleared by iir read");
    rd(3'd2, 8'h01, "R2 nothing left");
    wr(3'd1, 8'h0F);
    irq_is(0, "R2 no re-arm while set");
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h02);
    irq_is(1, "R2 re-armed");
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h41);
    irq_is(0, "R1 txe masked");

    // single-entry receive
    rx_offer(8'h11, 1, "R5 accept");
    irq_is(1, "R1 rx data");
    rd(3'd5, 8'h61, "R5 data ready");
    rx_offer(8'h22, 0, "R5 depth one stall");
    rd(3'd2, 8'h04, "R1 iir rx");
    rd(3'd0, 8'h11, "R7 pop");
    rd(3'd0, 8'h00, "R7 empty read");

    // FIFO mode
    wr(3'd2, 8'h01);
    rd(3'd2, 8'hC1, "R6 fifo bits");
    for (int i = 0; i < DEPTH; i++) rx_offer(8'(8'h30 + i), 1, "R5 fill");
    rx_offer(8'hEE, 0, "R5 full stall");
    rd(3'd2, 8'hC4, "R6 iir rx fifo");
    rd(3'd0, 8'h30, "R7 order");
    wr(3'd2, 8'h03);
    rd(3'd5, 8'h60, "R6 rx reset flush");
    rx_offer(8'h51, 1, "R5 after flush");
    rx_offer(8'h52, 1, "R5 after flush");
    wr(3'd2, 8'h00);
    rd(3'd2, 8'h01, "R6 fifo off");
    rd(3'd5, 8'h60, "R6 mode change flush");

    // priority rx over txe
    wr(3'd1, 8'h0F);
    rx_offer(8'h66, 1, "R5 accept");
    rd(3'd2, 8'h04, "R1 rx above txe");
    rd(3'd0, 8'h66, "R7 pop");
    rd(3'd2, 8'h02, "R1 txe next");
    rd(3'd2, 8'h01, "R1 none");

    // loopback modem mapping and deltas
    wr(3'd4, 8'h10);
    rd(3'd2, 8'h00, "R1 modem cause");
    rd(3'd6, 8'h0A, "R10 dsr dcd drop");
    rd(3'd2, 8'h01, "R9 deltas cleared");
    wr(3'd4, 8'h1F);
    rd(3'd6, 8'hFB, "R10 rise no ri delta");
    wr(3'd4, 8'h1B);
    rd(3'd6, 8'hB4, "R10 ri trailing edge");
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h1F, "R3 mcr mask");
    rd(3'd6, 8'hF0, "R11 line map");

    // loopback data path
    wr(3'd0, 8'h77);
    rd(3'd2, 8'h04, "R11 looped byte");
    wr(3'd0, 8'h88);
    rd(3'd2, 8'h06, "R11 overrun cause");
    rd(3'd5, 8'h63, "R8 overrun bit");
    rd(3'd5, 8'h61, "R8 overrun cleared");
    rd(3'd0, 8'h77, "R11 first byte kept");
    rx_offer(8'h99, 1, "R11 external consumed");
    rd(3'd5, 8'h60, "R11 external discarded");

    // write masks concurrent read
    wr(3'd4, 8'h00);
    @(posedge clk); #1;
    bus_addr = 3'd6; bus_wdata = 8'h3C; bus_rd = 1; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0;
    rd(3'd6, 8'hA5, "R12 read suppressed");

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #1;
      bus_addr  = 3'($urandom_range(0, 7));
      bus_wdata = 8'($urandom);
      if (bus_addr == 3'd3) bus_wdata[7] = ($urandom_range(0, 3) == 0);
      bus_wr    = ($urandom_range(0, 3) == 0);
      bus_rd    = ($urandom_range(0, 2) == 0);
      rx_valid  = ($urandom_range(0, 1) == 1);
      rx_data   = 8'($urandom);
    end
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; rx_valid = 0;
    repeat (3) @(posedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule